// File: doc/BRIEF.md
# Byte-Memory Stored-Program Processor

A small sequencer that executes two-byte instructions out of a 256-cell, byte-wide memory. It holds sixteen 8-bit working registers, an 8-bit program counter and a 16-bit instruction register. Each instruction word is read from two neighbouring cells, with the first cell holding the upper byte. The top nibble of the word selects the operation and the remaining three nibbles are operands.

Five operations are supported: load a register from a cell, store a register into a cell, add two registers, jump when a register matches register 0, and stop. The memory itself sits outside the block. The processor drives a registered address, a write strobe and write data. It expects read data one clock after it presents an address, which is how a synchronous RAM behaves.

After reset the processor waits in the stopped state. A one-cycle start pulse sets the program counter to the start address and begins execution. The processor runs until it decodes a stop instruction and then waits for the next start pulse.

Top module: `byte_cpu`

## Requirements
- R1: After reset, `halted` is 1 and `mem_we` is 0, and both stay that way until a start pulse arrives.
- R2: While halted, a `start` pulse takes the value on `start_pc` as the program counter and clears `halted`. On the next cycle `mem_addr` equals that value, because it is the address of the first fetch.
- R3: An instruction word is the cell at the program counter (bits 15:8) followed by the cell at the program counter plus 1 (bits 7:0). Bits 15:12 are the opcode, 11:8 are field R, 7:4 are S, 3:0 are T, and 7:0 are the address XY. The program counter advances by 2 before the instruction executes, and the address wraps modulo 256.
- R4: Opcode 0x1 (1RXY) copies the byte in cell XY into register R.
- R5: Opcode 0x3 (3RXY) writes register R into cell XY, using a `mem_we` strobe that is high for exactly one cycle.
- R6: Opcode 0x5 (5RST) sets register R to S + T modulo 256. No carry or overflow state is kept.
- R7: Opcode 0xB (BRXY) sets the program counter to XY when register R equals register 0. Otherwise execution continues at the next instruction.
- R8: Opcode 0xC (C000) sets `halted`. The processor then performs no memory writes and stays halted until the next start pulse.
- R9: Opcodes that are not listed above leave the registers and memory unchanged, and execution continues at the next instruction.
- R10: A `start` pulse while the processor is running has no effect.
- R11: Timing per instruction: 4 cycles for add, jump, no-op and stop, 5 cycles for store, and 6 cycles for load. `halted` rises on the clock edge that ends the stop instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin execution |
| start_pc | input | 8 | Address of the first instruction |
| mem_addr | output | 8 | Registered memory address |
| mem_we | output | 1 | Registered write strobe |
| mem_wdata | output | 8 | Registered write data |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| halted | output | 1 | High while stopped |

## Verification
On every cycle, the assertions check that the write strobe lasts one cycle, that no write happens while halted, that the halted state holds until a start pulse, that a start pulse loads the fetch address, and that the program counter advances by two after each fetch. The per-operation results need the bench's programs and its instruction-level model, which tracks the exact cycle of the halt and every write address and data value. These results are the load and store data, the add wrap-around, branch taken versus not taken, no-op opcodes, and a start pulse ignored in mid-run.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);
  localparam int INSN_W = 2 * BYTE_W;

  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h3;
  localparam logic [3:0] OPC_ADD   = 4'h5;
  localparam logic [3:0] OPC_JEQ   = 4'hB;
  localparam logic [3:0] OPC_STOP  = 4'hC;

  typedef enum logic [2:0] {
    SQ_HALT, SQ_FHI, SQ_FLO, SQ_FCAP, SQ_EXEC, SQ_LDADR, SQ_LDWB, SQ_STWR
  } seq_state_e;
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int W = 8,
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [IW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [IW-1:0] ra_c,
  output logic [W-1:0]  rd_c,
  output logic [W-1:0]  rd_zero
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a    = regs[ra_a];
  assign rd_b    = regs[ra_b];
  assign rd_c    = regs[ra_c];
  assign rd_zero = regs[0];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] sum,
  output logic         equal
);
  assign sum   = add_a + add_b;
  assign equal = (cmp_a == cmp_b);
endmodule

// File: rtl/cpu_sequencer.sv
module cpu_sequencer
  import cpu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  parameter int RW = RIDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_pc,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          halted,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [RW-1:0] rf_ra_s,
  output logic [RW-1:0] rf_ra_t,
  output logic [RW-1:0] rf_ra_r,
  input  logic [DW-1:0] rf_rd_r,
  input  logic [DW-1:0] alu_sum,
  input  logic          alu_equal
);
  seq_state_e        state;
  logic [AW-1:0]     pc;
  logic [2*DW-1:0]   ir;
  logic [3:0]        opc;
  logic [AW-1:0]     xy;

  assign opc      = ir[2*DW-1 -: 4];
  assign xy       = ir[AW-1:0];
  assign rf_ra_r  = ir[11:8];
  assign rf_ra_s  = ir[7:4];
  assign rf_ra_t  = ir[3:0];
  assign rf_waddr = ir[11:8];
  assign rf_we    = ((state == SQ_EXEC) && (opc == OPC_ADD)) || (state == SQ_LDWB);
  assign rf_wdata = (state == SQ_LDWB) ? mem_rdata : alu_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_HALT;
      pc        <= '0;
      ir        <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      halted    <= 1'b1;
    end else begin
      mem_we <= 1'b0;
      unique case (state)
        SQ_HALT: begin
          if (start) begin
            pc       <= start_pc;
            mem_addr <= start_pc;
            halted   <= 1'b0;
            state    <= SQ_FHI;
          end
        end
        SQ_FHI: begin
          mem_addr <= pc + AW'(1);
          state    <= SQ_FLO;
        end
        SQ_FLO: begin
          ir[2*DW-1:DW] <= mem_rdata;
          state         <= SQ_FCAP;
        end
        SQ_FCAP: begin
          ir[DW-1:0] <= mem_rdata;
          pc         <= pc + AW'(2);
          mem_addr   <= pc + AW'(2);
          state      <= SQ_EXEC;
        end
        SQ_EXEC: begin
          state <= SQ_FHI;
          case (opc)
            OPC_LOAD: begin
              mem_addr <= xy;
              state    <= SQ_LDADR;
            end
            OPC_STORE: begin
              mem_addr  <= xy;
              mem_we    <= 1'b1;
              mem_wdata <= rf_rd_r;
              state     <= SQ_STWR;
            end
            OPC_JEQ: begin
              if (alu_equal) begin
                pc       <= xy;
                mem_addr <= xy;
              end
            end
            OPC_STOP: begin
              halted <= 1'b1;
              state  <= SQ_HALT;
            end
            default: ;
          endcase
        end
        SQ_LDADR: state <= SQ_LDWB;
        SQ_LDWB: begin
          mem_addr <= pc;
          state    <= SQ_FHI;
        end
        SQ_STWR: begin
          mem_addr <= pc;
          state    <= SQ_FHI;
        end
        default: state <= SQ_HALT;
      endcase
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R5
  AST_NO_WR_HALTED: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> halted); // R8
  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (halted && start) |=> (!halted && mem_addr == $past(start_pc))); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FCAP) |=> (pc == $past(pc) + AW'(2))); // R3
  AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FHI && start) |=> (state == SQ_FLO)); // R10
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              halted
);
  logic              rf_we;
  logic [RIDX_W-1:0] rf_waddr, rf_ra_s, rf_ra_t, rf_ra_r;
  logic [BYTE_W-1:0] rf_wdata, rd_s, rd_t, rd_r, rd_zero;
  logic [BYTE_W-1:0] alu_sum;
  logic              alu_equal;

  cpu_sequencer #(.AW(ADDR_W), .DW(BYTE_W), .RW(RIDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_pc(start_pc),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .halted(halted),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_ra_s(rf_ra_s), .rf_ra_t(rf_ra_t), .rf_ra_r(rf_ra_r),
    .rf_rd_r(rd_r), .alu_sum(alu_sum), .alu_equal(alu_equal)
  );

  cpu_regfile #(.W(BYTE_W), .N(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_a(rf_ra_s), .rd_a(rd_s), .ra_b(rf_ra_t), .rd_b(rd_t),
    .ra_c(rf_ra_r), .rd_c(rd_r), .rd_zero(rd_zero)
  );

  cpu_alu #(.W(BYTE_W)) u_alu (
    .add_a(rd_s), .add_b(rd_t), .cmp_a(rd_r), .cmp_b(rd_zero),
    .sum(alu_sum), .equal(alu_equal)
  );
endmodule

// File: tb/byte_cpu_tb.sv
module byte_cpu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] start_pc = 8'h00;
  logic [7:0] mem_addr, mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic       mem_we, halted;

  logic [7:0]  mem [256];
  logic [7:0]  mm  [256];
  logic [7:0]  mr  [16];
  logic [15:0] wq  [$];
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  byte_cpu u_dut (
    .clk(clk), .rst(rst), .start(start), .start_pc(start_pc),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Instruction-level model: fills wq with writes, returns cycles until halt
  task automatic model(input logic [7:0] sa, output int ncyc);
    logic [7:0] pc, hi, lo;
    logic [3:0] r, s, t;
    pc = sa;
    ncyc = 0;
    for (int g = 0; g < 2000; g++) begin
      hi = mm[pc];
      lo = mm[8'(pc + 8'd1)];
      pc = pc + 8'd2;
      ncyc += 4;
      r = hi[3:0]; s = lo[7:4]; t = lo[3:0];
      if (hi[7:4] == 4'h1) begin
        mr[r] = mm[lo]; ncyc += 2;
      end else if (hi[7:4] == 4'h3) begin
        mm[lo] = mr[r]; wq.push_back({lo, mr[r]}); ncyc += 1;
      end else if (hi[7:4] == 4'h5) begin
        mr[r] = mr[s] + mr[t];
      end else if (hi[7:4] == 4'hB) begin
        if (mr[r] == mr[0]) pc = lo;
      end else if (hi[7:4] == 4'hC) begin
        break;
      end
    end
  endtask

  task automatic run(input logic [7:0] sa, input int midk, input logic [7:0] mid_pc);
    int n;
    logic [15:0] w;
    for (int i = 0; i < 256; i++) mm[i] = mem[i];
    model(sa, n);
    @(negedge clk);
    start = 1'b1; start_pc = sa;
    @(posedge clk); #1;
    start = 1'b0;
    chk(mem_addr == sa, "R2 first fetch address", mem_addr, sa);
    chk(halted == 1'b0, "R2 halted cleared", halted, 0);
    for (int k = 1; k <= n + 3; k++) begin
      @(posedge clk); #1;
      if (k == midk) begin start = 1'b1; start_pc = mid_pc; end
      if (k == midk + 1) start = 1'b0;
      chk(halted == (k >= n), "R11/R8 halted timing", halted, (k >= n));
      if (mem_we) begin
        if (wq.size() == 0) chk(1'b0, "R5 unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          w = wq.pop_front();
          chk({mem_addr, mem_wdata} == w, "R5 write addr/data", {mem_addr, mem_wdata}, w);
        end
      end
    end
    chk(wq.size() == 0, "R5 missing writes", wq.size(), 0);
    begin
      bit same = 1'b1;
      for (int i = 0; i < 256; i++) if (mem[i] !== mm[i]) same = 1'b0;
      chk(same, "R3 memory image matches model", same, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) mr[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(halted == 1'b1, "R1 halted in reset", halted, 1);
    rst = 1'b0;
    repeat (4) begin
      @(posedge clk); #1;
      chk(halted == 1'b1 && mem_we == 1'b0, "R1 idle after reset", {halted, mem_we}, 2);
    end

    // Program 1 at A0: load, load, add, store, stop; mid-run start ignored
    mem[8'hA0] = 8'h15; mem[8'hA1] = 8'h6C;
    mem[8'hA2] = 8'h16; mem[8'hA3] = 8'h6D;
    mem[8'hA4] = 8'h50; mem[8'hA5] = 8'h56;
    mem[8'hA6] = 8'h30; mem[8'hA7] = 8'h6E;
    mem[8'hA8] = 8'hC0; mem[8'hA9] = 8'h00;
    mem[8'h6C] = 8'h7F; mem[8'h6D] = 8'h03;
    run(8'hA0, 10, 8'h00);
    chk(mem[8'h6E] == 8'h82, "R4/R6 load-add-store result", mem[8'h6E], 8'h82);
    chk(mem[8'h6E] == 8'h82, "R10 mid-run start ignored", mem[8'h6E], 8'h82);

    // Program 2 at 00: add wraps modulo 256
    mem[8'h00] = 8'h1A; mem[8'h01] = 8'h80;
    mem[8'h02] = 8'h1B; mem[8'h03] = 8'h81;
    mem[8'h04] = 8'h5C; mem[8'h05] = 8'hAB;
    mem[8'h06] = 8'h3C; mem[8'h07] = 8'h82;
    mem[8'h08] = 8'hC0; mem[8'h09] = 8'h00;
    mem[8'h80] = 8'hF0; mem[8'h81] = 8'h20;
    run(8'h00, -5, 8'h00);
    chk(mem[8'h82] == 8'h10, "R6 add wraps", mem[8'h82], 8'h10);

    // Program 3 at 10: branch taken, branch not taken, unknown opcode
    mem[8'h10] = 8'h11; mem[8'h11] = 8'h40;
    mem[8'h12] = 8'h10; mem[8'h13] = 8'h41;
    mem[8'h14] = 8'hB1; mem[8'h15] = 8'h20;
    mem[8'h16] = 8'h31; mem[8'h17] = 8'h50;
    mem[8'h20] = 8'h12; mem[8'h21] = 8'h42;
    mem[8'h22] = 8'hB2; mem[8'h23] = 8'h30;
    mem[8'h24] = 8'h32; mem[8'h25] = 8'h51;
    mem[8'h26] = 8'h70; mem[8'h27] = 8'h00;
    mem[8'h28] = 8'h31; mem[8'h29] = 8'h52;
    mem[8'h2A] = 8'hC0; mem[8'h2B] = 8'h00;
    mem[8'h40] = 8'h07; mem[8'h41] = 8'h07; mem[8'h42] = 8'h09;
    run(8'h10, -5, 8'h00);
    chk(mem[8'h50] == 8'h00, "R7 taken branch skipped store", mem[8'h50], 0);
    chk(mem[8'h51] == 8'h09, "R7 untaken branch falls through", mem[8'h51], 9);
    chk(mem[8'h52] == 8'h07, "R9 unknown opcode is no-op", mem[8'h52], 7);

    // Program 4: lone stop at FE
    mem[8'hFE] = 8'hC0; mem[8'hFF] = 8'h00;
    run(8'hFE, -5, 8'h00);
    repeat (5) begin
      @(posedge clk); #1;
      chk(halted == 1'b1 && mem_we == 1'b0, "R8 stays halted", {halted, mem_we}, 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule